// File: doc/BRIEF.md
# Serial Control Register File Slave

This block is a two-wire serial slave that holds an eleven-entry bank of 8-bit control registers for an audio signal path. The registers cover the source selector, loudness, volume, bass/treble, four per-speaker attenuators (front left, rear left, front right, rear right), input gain, mid-band and mute control. A host writes them by sending the chip address, a subaddress byte and one or more data bytes. A read returns a single status byte built from four live flag inputs.

SCL and SDA are sampled by the system clock through two-flop synchronisers. SDA is driven open drain: `sda_oe_o` high means the line is pulled low. In the subaddress byte, the low nibble picks the register and bit 4 turns on auto-increment. The index counter is four bits wide, so it wraps modulo 16 even though only indices 0 to 10 hold registers. Bytes aimed at indices 11 to 15 are acknowledged and then dropped.

After an address mismatch or a master NACK, the slave goes quiet and ignores the bus until the next STOP. A START is only taken when a STOP has been seen since the last accepted START or since reset.

Top module: `ctl_i2c_regfile`

## Requirements
- R1: The slave acknowledges an address byte by driving SDA low during the ninth clock only if bits 7..1 equal `{DEV_ADDR[6:1], addr_sel_i}` (default DEV_ADDR 7'h44, so write byte 8'h88 with select 0 and 8'h8A with select 1); SDA is only changed while SCL is low.
- R2: Bit 0 of the address byte is the direction, 0 write and 1 read; a read transfer never changes a register.
- R3: Bytes are received MSB first; a data byte written to index k (k < 11) appears in `regs_o[8k+7:8k]`, with `wr_stb_o` high for exactly one cycle and `wr_idx_o` = k.
- R4: In the subaddress byte, bits 3..0 are the register index, bit 4 enables auto-increment and bits 7..5 have no effect.
- R5: With auto-increment, the index advances by one after each data byte and wraps from 15 to 0; bytes at indices 11..15 are acknowledged but change no register and raise no strobe.
- R6: Without auto-increment, every data byte of the transfer overwrites the same register until STOP.
- R7: A START is ignored (no acknowledge, no state change) unless a STOP has occurred since the previous accepted START; the first START after reset is accepted.
- R8: A read returns `{4'b0000, status_i}`, where status_i[0] is the active-low pause flag, [1] zero-cross mute, [2] soft mute and [3] stereo, sent MSB first and sampled when each byte starts.
- R9: A master ACK after a read byte sends a freshly sampled status byte; a master NACK ends the read, and the slave leaves SDA released until the next STOP.
- R10: After a non-matching address, the slave does not acknowledge, drives no SDA and writes nothing until the next STOP.
- R11: After reset, all registers are zero, SDA is released and no strobe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_sel_i | input | 1 | Address select bit (device address LSB) |
| status_i | input | 4 | Status flags: pause_n, zero-cross mute, soft mute, stereo |
| regs_o | output | 88 | Register contents, index k at bits 8k+7:8k |
| wr_stb_o | output | 1 | One-cycle pulse when a register is written |
| wr_idx_o | output | 4 | Index of the register written |

## Verification
The assertions check several rules on every cycle. SDA never changes while SCL stays high. The slave drives SDA outside the read shift only in an acknowledge phase. It stays silent and writes nothing after a mismatch. Each strobe lasts one cycle and names an existing register. Behaviour that depends on the whole byte sequence can only be shown by the bench's scenarios: the modulo-16 wrap that drops five bytes, repeated overwrites without auto-increment, the refused START before a STOP, and the status sampled again after each master ACK.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int DW       = 8;
  localparam int IDX_W    = 4;   // subaddress index field, wraps modulo 16
  localparam int INC_BIT  = 4;   // auto-increment flag in subaddress
  localparam int STAT_W   = 4;

  localparam int REG_SRC_SEL = 0;
  localparam int REG_LOUD    = 1;
  localparam int REG_VOL     = 2;
  localparam int REG_TONE    = 3;
  localparam int REG_SPK_FL  = 4;
  localparam int REG_SPK_RL  = 5;
  localparam int REG_SPK_FR  = 6;
  localparam int REG_SPK_RR  = 7;
  localparam int REG_IN_GAIN = 8;
  localparam int REG_MID     = 9;
  localparam int REG_MUTE    = 10;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_ADDR, BUS_SUB, BUS_DATA, BUS_READ, BUS_SKIP
  } bus_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile import ctl_i2c_pkg::*; #(
  parameter int NREG = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DW-1:0]        data_i,
  output logic [NREG*DW-1:0]   regs_o,
  output logic                 stb_o,
  output logic [IDX_W-1:0]     stb_idx_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                val_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))        val_q <= data_i;
    end
    assign regs_o[g*DW +: DW] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o     <= 1'b0;
      stb_idx_o <= '0;
    end else begin
      stb_o <= we_i && (int'(idx_i) < NREG);
      if (we_i) stb_idx_o <= idx_i;
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);  // R3
  AST_STB_IDX_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (int'(stb_idx_o) < NREG));  // R5
endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile import ctl_i2c_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         NREG        = 11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 addr_sel_i,
  input  logic [STAT_W-1:0]    status_i,
  output logic [NREG*DW-1:0]   regs_o,
  output logic                 wr_stb_o,
  output logic [IDX_W-1:0]     wr_idx_o
);
  logic scl_q, scl_r, scl_f, sda_q, sda_r, sda_f;

  line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk_i, .rst_ni, .d_i(scl_i), .lvl_o(scl_q), .rise_o(scl_r), .fall_o(scl_f));
  line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk_i, .rst_ni, .d_i(sda_i), .lvl_o(sda_q), .rise_o(sda_r), .fall_o(sda_f));

  logic start_c, stop_c;
  assign start_c = sda_f & scl_q;
  assign stop_c  = sda_r & scl_q;

  logic [6:0]    my_addr;
  logic [DW-1:0] stat_byte;
  assign my_addr   = {DEV_ADDR[6:1], addr_sel_i};
  assign stat_byte = {{(DW-STAT_W){1'b0}}, status_i};

  bus_state_e       state;
  logic             armed, ack_ph, rd, mack, oe, we_q;
  logic [3:0]       cnt;
  logic [DW-1:0]    sh, tx, wdata_q;
  logic [IDX_W-1:0] idx, widx_q;
  logic             inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= BUS_IDLE; armed <= 1'b1; ack_ph <= 1'b0; rd <= 1'b0; mack <= 1'b0;
      oe <= 1'b0; we_q <= 1'b0; cnt <= '0; sh <= '0; tx <= '0; wdata_q <= '0;
      idx <= '0; widx_q <= '0; inc <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_c) begin
        state <= BUS_IDLE; armed <= 1'b1; ack_ph <= 1'b0; oe <= 1'b0; cnt <= '0;
      end else if (start_c && armed) begin
        state <= BUS_ADDR; armed <= 1'b0; ack_ph <= 1'b0; oe <= 1'b0; cnt <= '0;
      end else begin
        unique case (state)
          BUS_ADDR, BUS_SUB, BUS_DATA: begin
            if (!ack_ph) begin
              if (scl_r) begin
                sh  <= {sh[DW-2:0], sda_q};
                cnt <= cnt + 4'd1;
              end else if (scl_f && cnt == 4'd8) begin
                cnt <= '0;
                if (state == BUS_ADDR) begin
                  if (sh[7:1] == my_addr) begin
                    ack_ph <= 1'b1; oe <= 1'b1; rd <= sh[0];
                  end else begin
                    state <= BUS_SKIP;
                  end
                end else if (state == BUS_SUB) begin
                  ack_ph <= 1'b1; oe <= 1'b1;
                  idx <= sh[IDX_W-1:0]; inc <= sh[INC_BIT];
                end else begin
                  ack_ph <= 1'b1; oe <= 1'b1;
                  we_q <= (int'(idx) < NREG); widx_q <= idx; wdata_q <= sh;
                  if (inc) idx <= idx + IDX_W'(1);
                end
              end
            end else if (scl_f) begin
              ack_ph <= 1'b0;
              oe     <= 1'b0;
              if (state == BUS_ADDR) begin
                if (rd) begin
                  state <= BUS_READ; tx <= stat_byte; oe <= ~stat_byte[DW-1];
                end else begin
                  state <= BUS_SUB;
                end
              end else if (state == BUS_SUB) begin
                state <= BUS_DATA;
              end
            end
          end
          BUS_READ: begin
            if (!ack_ph) begin
              if (scl_f) begin
                if (cnt == 4'd7) begin
                  oe <= 1'b0; ack_ph <= 1'b1; cnt <= '0;
                end else begin
                  cnt <= cnt + 4'd1;
                  tx  <= {tx[DW-2:0], 1'b0};
                  oe  <= ~tx[DW-2];
                end
              end
            end else if (scl_r) begin
              mack <= ~sda_q;
            end else if (scl_f) begin
              ack_ph <= 1'b0;
              if (mack) begin
                tx <= stat_byte; oe <= ~stat_byte[DW-1];
              end else begin
                state <= BUS_SKIP; oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe;

  ctl_regfile #(.NREG(NREG)) u_rf (
    .clk_i, .rst_ni, .we_i(we_q), .idx_i(widx_q), .data_i(wdata_q),
    .regs_o, .stb_o(wr_stb_o), .stb_idx_o(wr_idx_o));

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && $past(scl_q)) |-> $stable(oe));  // R1
  AST_DRIVE_ONLY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && state != BUS_READ) |-> ack_ph);  // R1
  AST_SKIP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == BUS_SKIP) |-> (!oe && !we_q));  // R10
  AST_WRITE_FROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(state == BUS_DATA));  // R2
endmodule

// File: tb/sim_ctl_i2c_regfile.sv
`timescale 1ns/1ps
module sim_ctl_i2c_regfile;
  localparam int NREG = 11;
  localparam int Q    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic [3:0] status = 4'h0;
  logic sda_oe, wr_stb;
  logic [3:0] wr_idx;
  logic [NREG*8-1:0] regs;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  ctl_i2c_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .status_i(status), .regs_o(regs),
    .wr_stb_o(wr_stb), .wr_idx_o(wr_idx));

  int n_tests = 0, n_fail = 0, stb_cnt = 0;
  logic [3:0] last_idx = '0;
  logic [7:0] model [NREG];

  always @(posedge clk) if (rst_n && wr_stb) begin stb_cnt++; last_idx = wr_idx; end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0; tick(Q);
    end
    send_bit(~m_ack);
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, regs[i*8 +: 8], model[i]);
  endtask

  // {subaddress, data, target index}
  localparam logic [19:0] VEC [5] = '{
    {8'hE0, 8'hA1, 4'd0}, {8'h02, 8'h3C, 4'd2}, {8'hA5, 8'hF0, 4'd5},
    {8'h0A, 8'h81, 4'd10}, {8'h0B, 8'h77, 4'd11}};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int s0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // R11 reset state
    chk("R11 regs", {31'b0, regs == '0}, 32'd1);
    chk("R11 sda", {31'b0, sda_oe}, 32'd0);
    chk("R11 stb", stb_cnt, 0);

    // R3 R4 R5: single writes from table, no auto-increment
    for (int v = 0; v < 5; v++) begin
      s0 = stb_cnt;
      bus_start();
      send_byte(8'h88, ack); chk("R1 addr ack", {31'b0, ack}, 32'd1);
      send_byte(VEC[v][19:12], ack);
      send_byte(VEC[v][11:4], ack); chk("R5 data ack", {31'b0, ack}, 32'd1);
      bus_stop();
      if (int'(VEC[v][3:0]) < NREG) begin
        model[VEC[v][3:0]] = VEC[v][11:4];
        chk("R3 strobe", stb_cnt - s0, 1);
        chk("R4 index", {28'b0, last_idx}, {28'b0, VEC[v][3:0]});
      end else begin
        chk("R5 discard strobe", stb_cnt - s0, 0);
      end
      cmp_regs("R3 R4 regs");
    end

    // R10 mismatch, then R7 restart without STOP is refused
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h90, ack); chk("R10 nack", {31'b0, ack}, 32'd0);
    bus_start();
    send_byte(8'h88, ack); chk("R7 restart ignored", {31'b0, ack}, 32'd0);
    send_byte(8'h02, ack); chk("R10 silent", {31'b0, ack}, 32'd0);
    bus_stop();
    chk("R10 no write", stb_cnt - s0, 0);
    cmp_regs("R10 regs");
    bus_start();
    send_byte(8'h88, ack); chk("R7 start after stop", {31'b0, ack}, 32'd1);
    bus_stop();

    // R1 address select input
    addr_sel = 1'b1;
    bus_start(); send_byte(8'h88, ack); chk("R1 sel mismatch", {31'b0, ack}, 32'd0); bus_stop();
    bus_start(); send_byte(8'h8A, ack); chk("R1 sel match", {31'b0, ack}, 32'd1);
    send_byte(8'h01, ack); send_byte(8'h5A, ack); bus_stop();
    model[1] = 8'h5A; cmp_regs("R1 sel write");
    addr_sel = 1'b0;

    // R5 auto-increment wraps modulo 16
    s0 = stb_cnt;
    bus_start(); send_byte(8'h88, ack); send_byte(8'h18, ack);
    for (int k = 0; k < 9; k++) begin
      send_byte(8'hD0 + 8'(k), ack);
      chk("R5 burst ack", {31'b0, ack}, 32'd1);
    end
    bus_stop();
    model[8] = 8'hD0; model[9] = 8'hD1; model[10] = 8'hD2; model[0] = 8'hD8;
    cmp_regs("R5 wrap regs");
    chk("R5 wrap strobes", stb_cnt - s0, 4);
    chk("R5 wrap last idx", {28'b0, last_idx}, 32'd0);

    // R6 no increment: repeated overwrite
    s0 = stb_cnt;
    bus_start(); send_byte(8'h88, ack); send_byte(8'h03, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop();
    model[3] = 8'h33; cmp_regs("R6 regs");
    chk("R6 strobes", stb_cnt - s0, 3);
    chk("R6 idx", {28'b0, last_idx}, 32'd3);

    // R8 R9 read with status refresh, NACK ends the read
    s0 = stb_cnt;
    status = 4'hA;
    bus_start(); send_byte(8'h89, ack); chk("R2 read ack", {31'b0, ack}, 32'd1);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); rb[i] = sda_line; tick(Q); scl = 1'b0; tick(Q);
    end
    chk("R8 status byte", {24'b0, rb}, 32'h0A);
    status = 4'h5;
    send_bit(1'b0);
    recv_byte(1'b0, rb); chk("R9 refreshed status", {24'b0, rb}, 32'h05);
    recv_byte(1'b0, rb); chk("R9 released after nack", {24'b0, rb}, 32'hFF);
    bus_stop();
    chk("R9 sda idle", {31'b0, sda_oe}, 32'd0);
    chk("R2 read no write", stb_cnt - s0, 0);
    cmp_regs("R2 regs after read");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule